// File: doc/BRIEF.md
# Dice Game Referee

This block judges a game of dice between two players. Each player owns one single-cycle press input, already cleaned of bounce. Two counters outside the block keep stepping through the faces 1 to 6. When a press is accepted, the block copies both counter values as that player's pair of dice and adds them to form the roll's score. The latched faces and scores are held on registered outputs so that a display driver can show them.

A round is complete once player A and then player B have each rolled once. On the following clock edge the block applies the rule for the current round. In the opening round a score of 7 or 11 wins. In later rounds a player wins by repeating the score that the same player made in the opening round. In round six, if nobody repeats, the higher score decides. A decision puts a winner code on the output, sends the round counter back to 1 and moves a game number on.

Top module: `dice_referee`

## Requirements
- R1: After reset, winner is 00, round_num is 1, game_num is 1, and all latched faces and scores are 0.
- R2: An accepted press copies die_x and die_y into that player's face outputs and their sum into the score output, all visible one cycle after the press. A second press by player A in the same round changes nothing.
- R3: A press from player B is ignored until player A has rolled in the current round.
- R4: Evaluation happens on the edge after both players have rolled. In round 1, a score of 7 or 11 wins, and player A wins if both qualify. If round 1 has no winner, winner becomes 00 and round_num becomes 2.
- R5: In rounds 2 to 6, a player wins whose score equals that player's own round-1 score, and player A wins if both match. With no winner, round_num increments.
- R6: In round 6, if neither player matches, player A wins when A's score is strictly greater and player B wins otherwise, including a tie.
- R7: The winner code is 10 for player A and 01 for player B. After a decision round_num returns to 1, and the code is held until the next round-1 evaluation.
- R8: game_num increments on every decision and wraps from 6 to 1.
- R9: Each player's round-1 score is stored only during a round-1 evaluation. Rolls in later rounds do not change the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| press_a | input | 1 | Roll pulse of player A |
| press_b | input | 1 | Roll pulse of player B |
| die_x | input | 3 | First free-running face, 1 to 6 |
| die_y | input | 3 | Second free-running face, 1 to 6 |
| a_die_x | output | 3 | Player A latched first face |
| a_die_y | output | 3 | Player A latched second face |
| a_sum | output | 4 | Player A score |
| b_die_x | output | 3 | Player B latched first face |
| b_die_y | output | 3 | Player B latched second face |
| b_sum | output | 4 | Player B score |
| round_num | output | 3 | Current round, 1 to 6 |
| winner | output | 2 | 10 = A won, 01 = B won, 00 = none |
| game_num | output | 3 | Game number, 1 to 6 |

## Verification
Latched faces and scores appear one cycle after the accepted press. The winner code, round_num and game_num change one cycle after player B's accepted press, which is the evaluation edge. The bench drives each press for one cycle from the falling edge. It reads the faces after that same cycle, and it reads the round results one falling edge later, after the evaluation edge has passed. Checks that expect nothing to happen, such as an early press by B or a repeated press by A, read the outputs after the press and before any further roll.

// File: rtl/dice_pkg.sv
package dice_pkg;
  localparam logic [1:0] VERDICT_NONE = 2'b00;
  localparam logic [1:0] VERDICT_A    = 2'b10;
  localparam logic [1:0] VERDICT_B    = 2'b01;
  localparam int unsigned LUCKY_LOW   = 7;
  localparam int unsigned LUCKY_HIGH  = 11;

  function automatic logic is_lucky(input logic [7:0] score);
    return (score == 8'(LUCKY_LOW)) || (score == 8'(LUCKY_HIGH));
  endfunction
endpackage

// File: rtl/roll_latch.sv
module roll_latch #(
  parameter int DIE_W = 3,
  localparam int SUM_W = DIE_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             press,
  input  logic             permit,
  input  logic             clear,
  input  logic [DIE_W-1:0] die0,
  input  logic [DIE_W-1:0] die1,
  output logic             done_q,
  output logic [DIE_W-1:0] d0_q,
  output logic [DIE_W-1:0] d1_q,
  output logic [SUM_W-1:0] sum_q
);
  logic capture;
  assign capture = press && permit && !done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      d0_q   <= '0;
      d1_q   <= '0;
      sum_q  <= '0;
    end else if (clear) begin
      done_q <= 1'b0;
    end else if (capture) begin
      done_q <= 1'b1;
      d0_q   <= die0;
      d1_q   <= die1;
      sum_q  <= SUM_W'(die0) + SUM_W'(die1);
    end
  end

  // R2: a capture shows the sampled faces and their sum one cycle later
  p_capture_sum_r2: assert property (@(posedge clk) disable iff (rst)
    capture |=> (done_q && d0_q == $past(die0) && d1_q == $past(die1) &&
                 sum_q == SUM_W'($past(die0)) + SUM_W'($past(die1))));

  // R2: nothing is captured once this player has rolled in the round
  p_no_recapture_r2: assert property (@(posedge clk) disable iff (rst)
    (done_q && !clear) |=> ($stable(d0_q) && $stable(d1_q) && $stable(sum_q)));
endmodule

// File: rtl/rule_eval.sv
module rule_eval
  import dice_pkg::*;
#(
  parameter int SUM_W      = 4,
  parameter int ROUND_W    = 3,
  parameter int MAX_ROUNDS = 6
) (
  input  logic [ROUND_W-1:0] round,
  input  logic [SUM_W-1:0]   score_a,
  input  logic [SUM_W-1:0]   score_b,
  input  logic [SUM_W-1:0]   target_a,
  input  logic [SUM_W-1:0]   target_b,
  output logic [1:0]         verdict
);
  logic hit_a, hit_b, final_round;

  always_comb begin
    final_round = (round == ROUND_W'(MAX_ROUNDS));
    if (round == ROUND_W'(1)) begin
      hit_a = is_lucky(8'(score_a));
      hit_b = is_lucky(8'(score_b));
    end else begin
      hit_a = (score_a == target_a);
      hit_b = (score_b == target_b);
    end
    if (hit_a)            verdict = VERDICT_A;
    else if (hit_b)       verdict = VERDICT_B;
    else if (final_round) verdict = (score_a > score_b) ? VERDICT_A : VERDICT_B;
    else                  verdict = VERDICT_NONE;
  end

  // R7: the verdict never carries both player bits
  always_comb begin
    p_verdict_code_r7: assert (verdict != 2'b11);
  end
endmodule

// File: rtl/dice_referee.sv
module dice_referee
  import dice_pkg::*;
#(
  parameter int DIE_W      = 3,
  parameter int MAX_ROUNDS = 6,
  parameter int GAME_WRAP  = 6,
  localparam int SUM_W     = DIE_W + 1,
  localparam int ROUND_W   = $clog2(MAX_ROUNDS + 1),
  localparam int GAME_W    = $clog2(GAME_WRAP + 1),
  localparam int PLAYERS   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               press_a,
  input  logic               press_b,
  input  logic [DIE_W-1:0]   die_x,
  input  logic [DIE_W-1:0]   die_y,
  output logic [DIE_W-1:0]   a_die_x,
  output logic [DIE_W-1:0]   a_die_y,
  output logic [SUM_W-1:0]   a_sum,
  output logic [DIE_W-1:0]   b_die_x,
  output logic [DIE_W-1:0]   b_die_y,
  output logic [SUM_W-1:0]   b_sum,
  output logic [ROUND_W-1:0] round_num,
  output logic [1:0]         winner,
  output logic [GAME_W-1:0]  game_num
);
  logic [PLAYERS-1:0] press_v, permit_v, done_v;
  logic [DIE_W-1:0]   fx [PLAYERS];
  logic [DIE_W-1:0]   fy [PLAYERS];
  logic [SUM_W-1:0]   sc [PLAYERS];
  logic               evaluate;
  logic [1:0]         verdict;
  logic [ROUND_W-1:0] round_q;
  logic [1:0]         winner_q;
  logic [GAME_W-1:0]  game_q;
  logic [SUM_W-1:0]   tgt_a_q, tgt_b_q;

  assign press_v  = {press_b, press_a};
  assign permit_v = {done_v[0], 1'b1};
  assign evaluate = &done_v;

  for (genvar p = 0; p < PLAYERS; p++) begin : g_player
    roll_latch #(.DIE_W(DIE_W)) u_roll (
      .clk(clk), .rst(rst), .press(press_v[p]), .permit(permit_v[p]),
      .clear(evaluate), .die0(die_x), .die1(die_y), .done_q(done_v[p]),
      .d0_q(fx[p]), .d1_q(fy[p]), .sum_q(sc[p]));
  end

  rule_eval #(.SUM_W(SUM_W), .ROUND_W(ROUND_W), .MAX_ROUNDS(MAX_ROUNDS)) u_rule (
    .round(round_q), .score_a(sc[0]), .score_b(sc[1]),
    .target_a(tgt_a_q), .target_b(tgt_b_q), .verdict(verdict));

  always_ff @(posedge clk) begin
    if (rst) begin
      round_q  <= ROUND_W'(1);
      winner_q <= VERDICT_NONE;
      game_q   <= GAME_W'(1);
      tgt_a_q  <= '0;
      tgt_b_q  <= '0;
    end else if (evaluate) begin
      if (round_q == ROUND_W'(1)) begin
        tgt_a_q  <= sc[0];
        tgt_b_q  <= sc[1];
        winner_q <= verdict;
      end
      if (verdict != VERDICT_NONE) begin
        winner_q <= verdict;
        round_q  <= ROUND_W'(1);
        game_q   <= (game_q == GAME_W'(GAME_WRAP)) ? GAME_W'(1) : game_q + GAME_W'(1);
      end else begin
        round_q  <= round_q + ROUND_W'(1);
      end
    end
  end

  assign a_die_x   = fx[0];
  assign a_die_y   = fy[0];
  assign a_sum     = sc[0];
  assign b_die_x   = fx[1];
  assign b_die_y   = fy[1];
  assign b_sum     = sc[1];
  assign round_num = round_q;
  assign winner    = winner_q;
  assign game_num  = game_q;

  // R3: player B can only have rolled when player A has
  p_b_follows_a_r3: assert property (@(posedge clk) disable iff (rst)
    done_v[1] |-> done_v[0]);

  // R4: both turn flags drop right after an evaluation
  p_flags_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (done_v[0] && done_v[1]) |=> (done_v == '0));

  // R5: the round stays within 1..MAX_ROUNDS
  p_round_range_r5: assert property (@(posedge clk) disable iff (rst)
    (round_q >= ROUND_W'(1)) && (round_q <= ROUND_W'(MAX_ROUNDS)));

  // R7: a decision sends the round back to 1
  p_round_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (evaluate && verdict != VERDICT_NONE) |=> (round_q == ROUND_W'(1)));

  // R8: the game number only steps by one, wrapping to 1
  p_game_step_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(game_q) |-> (game_q == (($past(game_q) == GAME_W'(GAME_WRAP)) ?
                                     GAME_W'(1) : $past(game_q) + GAME_W'(1))));

  // R9: targets only change across a round-1 evaluation
  p_target_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (round_q != ROUND_W'(1)) |=> ($stable(tgt_a_q) && $stable(tgt_b_q)));
endmodule

// File: tb/dice_referee_tb_top.sv
module dice_referee_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       press_a, press_b;
  logic [2:0] die_x, die_y;
  logic [2:0] a_die_x, a_die_y, b_die_x, b_die_y, round_num, game_num;
  logic [3:0] a_sum, b_sum;
  logic [1:0] winner;
  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #5 clk = ~clk;

  dice_referee dut_i (
    .clk(clk), .rst(rst), .press_a(press_a), .press_b(press_b),
    .die_x(die_x), .die_y(die_y), .a_die_x(a_die_x), .a_die_y(a_die_y),
    .a_sum(a_sum), .b_die_x(b_die_x), .b_die_y(b_die_y), .b_sum(b_sum),
    .round_num(round_num), .winner(winner), .game_num(game_num));

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic roll_a(input int x, input int y);
    @(negedge clk); die_x = 3'(x); die_y = 3'(y); press_a = 1'b1;
    @(negedge clk); press_a = 1'b0;
  endtask

  task automatic roll_b(input int x, input int y);
    @(negedge clk); die_x = 3'(x); die_y = 3'(y); press_b = 1'b1;
    @(negedge clk); press_b = 1'b0;
  endtask

  task automatic play(input int ax, input int ay, input int bx, input int by);
    roll_a(ax, ay);
    roll_b(bx, by);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1", "winner", winner, 0);
    check("R1", "round", round_num, 1);
    check("R1", "game", game_num, 1);
    check("R1", "a_sum", a_sum, 0);
    check("R1", "b_sum", b_sum, 0);
  endtask

  task automatic t_capture_and_a_lucky();
    roll_a(3, 4);
    check("R2", "a_die_x", a_die_x, 3);
    check("R2", "a_die_y", a_die_y, 4);
    check("R2", "a_sum", a_sum, 7);
    roll_a(6, 6);
    check("R2", "a_sum after repeat press", a_sum, 7);
    roll_b(1, 1);
    check("R2", "b_sum", b_sum, 2);
    @(negedge clk);
    check("R4", "winner A lucky 7", winner, 2);
    check("R8", "game", game_num, 2);
  endtask

  task automatic t_b_lucky();
    play(1, 2, 5, 6);
    check("R4", "winner B lucky 11", winner, 1);
    check("R8", "game", game_num, 3);
  endtask

  task automatic t_both_lucky();
    play(3, 4, 5, 2);
    check("R4", "A priority", winner, 2);
    check("R7", "round back to 1", round_num, 1);
  endtask

  task automatic t_match_b();
    roll_a(2, 2);
    check("R7", "winner held before eval", winner, 2);
    roll_b(2, 3);
    @(negedge clk);
    check("R4", "no winner clears code", winner, 0);
    check("R4", "round 2", round_num, 2);
    play(3, 3, 1, 4);
    check("R5", "B matches own target", winner, 1);
    check("R8", "game", game_num, 5);
  endtask

  task automatic t_round6_larger();
    play(2, 2, 2, 3);
    for (int r = 2; r <= 5; r++) play(4, 4, 4, 5);
    check("R5", "round 6 reached", round_num, 6);
    check("R5", "no winner yet", winner, 0);
    play(5, 5, 4, 5);
    check("R6", "A larger wins", winner, 2);
    check("R8", "game 6", game_num, 6);
  endtask

  task automatic t_round6_tie();
    play(2, 2, 2, 3);
    for (int r = 2; r <= 5; r++) play(4, 4, 4, 5);
    play(4, 4, 3, 5);
    check("R6", "tie goes to B", winner, 1);
    check("R8", "wrap to 1", game_num, 1);
  endtask

  task automatic t_b_early();
    roll_b(6, 6);
    check("R3", "b_sum unchanged", b_sum, 8);
    check("R3", "b_die_x unchanged", b_die_x, 3);
    play(3, 4, 1, 1);
    check("R3", "b roll after A", b_sum, 2);
    check("R4", "winner A", winner, 2);
  endtask

  task automatic t_target_kept();
    play(2, 2, 2, 3);
    for (int r = 2; r <= 5; r++) play(4, 4, 4, 5);
    play(2, 2, 6, 6);
    check("R9", "A matches round-1 target in round 6", winner, 2);
    check("R8", "game", game_num, 3);
  endtask

  initial begin
    rst = 1'b1; press_a = 1'b0; press_b = 1'b0; die_x = 3'd1; die_y = 3'd1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_capture_and_a_lucky();
    t_b_lucky();
    t_both_lucky();
    t_match_b();
    t_round6_larger();
    t_round6_tie();
    t_b_early();
    t_target_kept();
    done_flag = 1'b1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule